// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes one incoming Ethernet frame at a time and lays it out in a packet page of a shared buffer. A frame is offered with its byte length. Its bytes then arrive over a valid/ready byte stream. Before it asks for storage, the block checks the receive-control bits and works out the stored size. If the frame is accepted, it requests a page from an external allocator. It then writes the page one byte per cycle through a single RAM write port, in this order: a status word, a byte count, the payload (zero-padded to the minimum frame size), an optional CRC-32, one trailing data byte and a control byte.

A rejected frame still drains its bytes from the stream, but no page is written. A frame can be rejected because reception is disabled, because soft reset is set, because it is too long, or because the allocator reports that no page is free. When the control byte is in place, the block raises one single-cycle pulse. In that cycle it pushes the page number onto the receive queue, sets the receive interrupt and signals completion.

Top module: `rx_frame_writer`

## Requirements
- R1: A frame is taken only when `rx_ctrl[8]` (enable) is 1 and `rx_ctrl[15]` (soft reset) is 0. Otherwise its bytes are consumed, no page is requested, nothing is written and no completion pulse follows.
- R2: Bytes 2 (low) and 3 (high) of the page hold the byte count. The count is the padded length rounded down to even, plus 6, plus a further 4 when `rx_ctrl[9]` (strip CRC) is 0.
- R3: A frame whose byte count would exceed the page size (2048) is dropped without an allocator request.
- R4: Bytes 0 (low) and 1 (high) hold the status word. Bit 11 is set when the length exceeds 1518. Bit 12 is set when the length is odd.
- R5: Payload bytes start at page byte 4. A frame shorter than 64 bytes is stored as 64 bytes, with zeros after its data.
- R6: When `rx_ctrl[9]` is 0, the standard Ethernet CRC-32 (reflected, initial value all ones, final inversion) is stored least-significant byte first, directly after the even part of the payload. The CRC covers the padded frame, including an odd last byte. When `rx_ctrl[9]` is 1, no CRC is stored.
- R7: For a padded length that is odd, the last two page bytes are the final frame byte and then 0x60. Otherwise they are 0x00 and then 0x40.
- R8: Page writes go through one port, one byte per cycle, to one page. Writes in consecutive cycles go to ascending consecutive addresses, starting at 0.
- R9: `done`, `rxq_push` (carrying the page number) and `rcv_irq_set` pulse together for one cycle, exactly one cycle after the control byte is written.
- R10: `alloc_req` stays high until `alloc_ack`. If the acknowledge comes with `alloc_fail`, the frame's bytes are drained and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ctrl | input | 16 | Receive-control bits: 8 enable, 9 strip CRC, 15 soft reset |
| frm_valid | input | 1 | A frame of length `frm_len` is offered |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_ready | output | 1 | The block is idle and takes the offered frame |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | The block consumes the stream byte |
| alloc_req | output | 1 | Page request |
| alloc_ack | input | 1 | Allocator response strobe |
| alloc_fail | input | 1 | No page free (valid with `alloc_ack`) |
| alloc_page | input | PG_W | Granted page number (valid with `alloc_ack`) |
| ram_we | output | 1 | Page RAM byte write enable |
| ram_page | output | PG_W | Page being written |
| ram_addr | output | AW | Byte address within the page |
| ram_wdata | output | 8 | Byte written |
| rxq_push | output | 1 | Append page to the receive queue |
| rxq_page | output | PG_W | Page appended |
| rcv_irq_set | output | 1 | Set the receive interrupt |
| done | output | 1 | Frame stored |

## Verification
On an odd frame of 64 bytes or more, the block reads the last stream byte and folds it into the CRC in the same cycle. It writes that byte only after the four CRC bytes have been written. The bench checks the trailer order and the CRC value for lengths 101 and 1601, with the CRC both kept and stripped. The other overlap is the control-byte write with the completion pulse that follows it. The bench compares `done`, `rxq_push` and `rcv_irq_set` on every clock against a flag that records whether the previous cycle wrote the final expected byte. A pulse one cycle early or late is therefore reported.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_DRAIN, S_ALLOC, S_HDR, S_PAY, S_ODD, S_CRC, S_TAIL, S_CTRL, S_FIN
   } wr_state_e;

   // receive-control bit positions
   localparam int RC_EN    = 8;
   localparam int RC_STRIP = 9;
   localparam int RC_SRST  = 15;

   // status word bit positions
   localparam int ST_LONG = 11;
   localparam int ST_ODD  = 12;

   localparam logic [7:0]  CTL_ODD   = 8'h60;
   localparam logic [7:0]  CTL_EVEN  = 8'h40;
   localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

   // one byte through the reflected CRC-32 register
   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int i = 0; i < 8; i++)
         r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/rxw_sizer.sv
module rxw_sizer
   import rxw_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int PAGE_BYTES = 2048,
   parameter int MIN_FRAME  = 64,
   parameter int LONG_LIMIT = 1518
) (
   input  logic [LEN_W-1:0] len,
   input  logic [15:0]      ctrl,
   output logic             take,
   output logic             keep_crc,
   output logic [LEN_W-1:0] pad_len,
   output logic [15:0]      byte_cnt,
   output logic [15:0]      status
);
   localparam int CW = LEN_W + 2;

   logic [CW-1:0] cnt_w;
   logic          unused_ctrl;

   assign unused_ctrl = ^ctrl;

   always_comb begin
      pad_len  = (len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : len;
      keep_crc = !ctrl[RC_STRIP];
      // R2: even-rounded padded length + header/trailer, + CRC when kept
      cnt_w    = CW'({pad_len[LEN_W-1:1], 1'b0}) + CW'(6) + (keep_crc ? CW'(4) : CW'(0));
      byte_cnt = 16'(cnt_w);
      // R4
      status          = '0;
      status[ST_LONG] = (len > LEN_W'(LONG_LIMIT));
      status[ST_ODD]  = len[0];
      // R1, R3
      take = ctrl[RC_EN] && !ctrl[RC_SRST] && (cnt_w <= CW'(PAGE_BYTES));
   end

endmodule

// File: rtl/rxw_crc32.sv
module rxw_crc32
   import rxw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [7:0]  d,
   output logic [31:0] crc_out
);
   logic [31:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q <= CRC_SEED;
      else if (clr) reg_q <= CRC_SEED;
      else if (en)  reg_q <= crc32_step(reg_q, d);
   end

   assign crc_out = ~reg_q;

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
   import rxw_pkg::*;
#(
   parameter int PAGES      = 4,
   parameter int PAGE_BYTES = 2048,
   parameter int LEN_W      = 12,
   parameter int MIN_FRAME  = 64,
   parameter int LONG_LIMIT = 1518,
   localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int AW   = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      rx_ctrl,
   input  logic             frm_valid,
   input  logic [LEN_W-1:0] frm_len,
   output logic             frm_ready,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   output logic             byte_ready,
   output logic             alloc_req,
   input  logic             alloc_ack,
   input  logic             alloc_fail,
   input  logic [PG_W-1:0]  alloc_page,
   output logic             ram_we,
   output logic [PG_W-1:0]  ram_page,
   output logic [AW-1:0]    ram_addr,
   output logic [7:0]       ram_wdata,
   output logic             rxq_push,
   output logic [PG_W-1:0]  rxq_page,
   output logic             rcv_irq_set,
   output logic             done
);
   localparam int CW = LEN_W + 1;
   localparam logic [CW-1:0] C_ONE = CW'(1);
   localparam logic [AW-1:0] A_ONE = AW'(1);

   generate
      if (LEN_W > 15) begin : g_len_chk
         $error("LEN_W too wide for a 16-bit byte count");
      end
      if ((1 << AW) != PAGE_BYTES) begin : g_page_chk
         $error("PAGE_BYTES must be a power of two");
      end
      if (PAGE_BYTES < MIN_FRAME + 10) begin : g_min_chk
         $error("page cannot hold a minimum frame");
      end
   endgenerate

   wr_state_e        st;
   logic [CW-1:0]    cnt;
   logic [LEN_W-1:0] len_q, pad_q;
   logic             keep_q;
   logic [15:0]      stat_q, bc_q;
   logic [PG_W-1:0]  page_q;
   logic [AW-1:0]    wa;
   logic [7:0]       hold_q;

   logic             sz_take, sz_keep;
   logic [LEN_W-1:0] sz_pad;
   logic [15:0]      sz_cnt, sz_stat;
   logic [31:0]      crc_val;
   logic             crc_en;
   logic [7:0]       crc_d;
   logic             from_stream, take, odd_tail, pay_last;
   logic [CW-1:0]    even_m1;

   rxw_sizer #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MIN_FRAME(MIN_FRAME),
               .LONG_LIMIT(LONG_LIMIT)) u_size (
      .len(frm_len), .ctrl(rx_ctrl), .take(sz_take), .keep_crc(sz_keep),
      .pad_len(sz_pad), .byte_cnt(sz_cnt), .status(sz_stat));

   rxw_crc32 u_crc (
      .clk(clk), .rst_n(rst_n), .clr(st == S_IDLE), .en(crc_en), .d(crc_d), .crc_out(crc_val));

   assign from_stream = cnt < {1'b0, len_q};
   assign odd_tail    = pad_q[0];
   assign even_m1     = {1'b0, pad_q[LEN_W-1:1], 1'b0} - C_ONE;
   assign pay_last    = (cnt == even_m1);
   assign take        = byte_valid && byte_ready;

   always_comb begin
      frm_ready   = (st == S_IDLE);
      alloc_req   = (st == S_ALLOC);
      byte_ready  = 1'b0;
      ram_we      = 1'b0;
      ram_wdata   = 8'h00;
      crc_en      = 1'b0;
      crc_d       = byte_data;
      done        = (st == S_FIN);
      rxq_push    = done;
      rcv_irq_set = done;
      case (st)
         S_DRAIN: byte_ready = from_stream;
         S_HDR: begin
            ram_we = 1'b1;
            case (cnt[1:0])
               2'd0: ram_wdata = stat_q[7:0];
               2'd1: ram_wdata = stat_q[15:8];
               2'd2: ram_wdata = bc_q[7:0];
               default: ram_wdata = bc_q[15:8];
            endcase
         end
         S_PAY: begin
            byte_ready = from_stream;
            ram_we     = from_stream ? byte_valid : 1'b1;
            ram_wdata  = from_stream ? byte_data : 8'h00;
            crc_en     = ram_we;
            crc_d      = ram_wdata;
         end
         S_ODD: begin
            byte_ready = 1'b1;
            crc_en     = byte_valid;
         end
         S_CRC: begin
            ram_we    = 1'b1;
            ram_wdata = crc_val[{cnt[1:0], 3'b000} +: 8];
         end
         S_TAIL: begin
            ram_we    = 1'b1;
            ram_wdata = odd_tail ? hold_q : 8'h00;
         end
         S_CTRL: begin
            ram_we    = 1'b1;
            ram_wdata = odd_tail ? CTL_ODD : CTL_EVEN;
         end
         default: ;
      endcase
   end

   assign ram_page = page_q;
   assign ram_addr = wa;
   assign rxq_page = page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  cnt <= '0;    len_q <= '0;  pad_q <= '0;
         keep_q <= 1'b0; stat_q <= '0; bc_q <= '0;  page_q <= '0;
         wa <= '0;      hold_q <= '0;
      end else begin
         case (st)
            S_IDLE: if (frm_valid) begin
               len_q  <= frm_len;   pad_q <= sz_pad;  keep_q <= sz_keep;
               stat_q <= sz_stat;   bc_q  <= sz_cnt;  cnt    <= '0;
               st     <= sz_take ? S_ALLOC : S_DRAIN;
            end
            S_DRAIN: begin
               if (!from_stream) st <= S_IDLE;
               else if (take)    cnt <= cnt + C_ONE;
            end
            S_ALLOC: if (alloc_ack) begin
               if (alloc_fail) st <= S_DRAIN;
               else begin
                  page_q <= alloc_page;
                  wa     <= '0;
                  st     <= S_HDR;
               end
            end
            S_HDR: begin
               wa <= wa + A_ONE;
               if (cnt[1:0] == 2'd3) begin cnt <= '0; st <= S_PAY; end
               else cnt <= cnt + C_ONE;
            end
            S_PAY: if (ram_we) begin
               wa <= wa + A_ONE;
               if (pay_last) begin
                  cnt <= '0;
                  st  <= odd_tail ? S_ODD : (keep_q ? S_CRC : S_TAIL);
               end else cnt <= cnt + C_ONE;
            end
            S_ODD: if (take) begin
               hold_q <= byte_data;
               st     <= keep_q ? S_CRC : S_TAIL;
            end
            S_CRC: begin
               wa <= wa + A_ONE;
               if (cnt[1:0] == 2'd3) begin cnt <= '0; st <= S_TAIL; end
               else cnt <= cnt + C_ONE;
            end
            S_TAIL: begin wa <= wa + A_ONE; st <= S_CTRL; end
            S_CTRL: begin wa <= wa + A_ONE; st <= S_FIN; end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R9
   done_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(ram_we) && ($past(ram_wdata) == CTL_ODD || $past(ram_wdata) == CTL_EVEN)));

   // R10
   alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !alloc_ack) |=> alloc_req);

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + A_ONE && ram_page == $past(ram_page)));

   // R1
   disabled_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_ready && !rx_ctrl[RC_EN]) |=> !alloc_req);

endmodule

// File: tb/sim_rx_frame_writer.sv
module sim_rx_frame_writer;
   localparam int LEN_W = 12;
   localparam int PG_W  = 2;
   localparam int AW    = 11;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0]      rx_ctrl = '0;
   logic             frm_valid = 1'b0;
   logic [LEN_W-1:0] frm_len = '0;
   logic             frm_ready, byte_valid, byte_ready, alloc_req;
   logic [7:0]       byte_data;
   logic             alloc_ack = 1'b0, alloc_fail = 1'b0;
   logic [PG_W-1:0]  alloc_page = '0;
   logic             ram_we, rxq_push, rcv_irq_set, done;
   logic [PG_W-1:0]  ram_page, rxq_page;
   logic [AW-1:0]    ram_addr;
   logic [7:0]       ram_wdata;

   rx_frame_writer u0 (.*);

   int vec = 0, bad = 0;
   logic [7:0]  bq[$];
   logic [18:0] wq[$];
   string       tq[$];
   logic [18:0] e;
   string       etag;
   logic [PG_W-1:0] exp_page = '0;
   bit pend_done = 0, alloc_ok_exp = 0, prev_last = 0, last_now = 0;
   bit byte_took = 0, frm_took = 0, areq_s = 0;
   bit fail_next = 0;
   logic [PG_W-1:0] page_next = '0;
   int acnt = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: samples 2 ns before each rising edge
   initial forever begin
      @(negedge clk); #3;
      byte_took = byte_valid && byte_ready;
      frm_took  = frm_valid && frm_ready;
      areq_s    = alloc_req;
      last_now  = 0;
      if (rst_n) begin
         if (alloc_req && !alloc_ok_exp) chk(0, "R1 R3 unexpected alloc_req", 1, 0);
         if (ram_we) begin
            if (wq.size() == 0) chk(0, "R8 unexpected write", int'(ram_addr), 0);
            else begin
               e = wq.pop_front(); etag = tq.pop_front();
               chk({ram_addr, ram_wdata} == e && ram_page == exp_page, etag,
                   int'({ram_page, ram_addr, ram_wdata}), int'({exp_page, e}));
               if (wq.size() == 0) last_now = 1;
            end
         end
         if (done || prev_last || rxq_push || rcv_irq_set) begin
            chk(done && prev_last && rxq_push && rcv_irq_set && rxq_page == exp_page,
                "R9 completion pulse", int'({done, rxq_push, rcv_irq_set, rxq_page}),
                int'({prev_last, prev_last, prev_last, exp_page}));
            if (done) pend_done = 0;
         end
         prev_last = last_now;
      end
   end

   // byte source with random gaps
   initial begin
      byte_valid = 1'b0; byte_data = 8'h00;
      forever begin
         @(negedge clk);
         if (byte_took && bq.size() > 0) void'(bq.pop_front());
         byte_valid = (bq.size() > 0) && ($urandom_range(3) != 0);
         byte_data  = (bq.size() > 0) ? bq[0] : 8'h00;
      end
   end

   // allocator: answers two cycles after the request
   initial forever begin
      @(negedge clk);
      if (alloc_ack) begin alloc_ack = 1'b0; acnt = 0; end
      else if (areq_s) begin
         acnt++;
         if (acnt >= 2) begin
            alloc_ack = 1'b1; alloc_fail = fail_next; alloc_page = page_next;
         end
      end
   end

   task automatic push_w(input int a, input logic [7:0] d, input string t);
      wq.push_back({AW'(a), d}); tq.push_back(t);
   endtask

   function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r = c ^ {24'h0, d};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic frame(input int len, input logic [15:0] ctrl, input bit fail,
                        input logic [PG_W-1:0] pg, input string name);
      logic [7:0] fb[$];
      bit en, keep, acc;
      int pad, ev, bc, a, st;
      logic [31:0] crc;
      logic [7:0]  b;
      en   = ctrl[8] && !ctrl[15];
      keep = !ctrl[9];
      pad  = (len < 64) ? 64 : len;
      ev   = pad & ~1;
      bc   = ev + 6 + (keep ? 4 : 0);
      alloc_ok_exp = en && (bc <= 2048);
      acc  = alloc_ok_exp && !fail;
      for (int i = 0; i < len; i++) fb.push_back(8'($urandom));
      if (acc) begin
         st = ((len > 1518) ? 32'h800 : 0) | ((len % 2 == 1) ? 32'h1000 : 0);
         push_w(0, st[7:0], "R4 status lo");
         push_w(1, st[15:8], "R4 status hi");
         push_w(2, bc[7:0], "R2 count lo");
         push_w(3, bc[15:8], "R2 count hi");
         a = 4; crc = 32'hFFFFFFFF;
         for (int i = 0; i < ev; i++) begin
            b = (i < len) ? fb[i] : 8'h00;
            push_w(a, b, "R5 payload/pad"); a++;
            crc = crc_upd(crc, b);
         end
         if (pad % 2 == 1) crc = crc_upd(crc, fb[len-1]);
         crc = ~crc;
         if (keep) for (int k = 0; k < 4; k++) begin
            push_w(a, crc[8*k +: 8], "R6 crc byte"); a++;
         end
         push_w(a, (pad % 2 == 1) ? fb[len-1] : 8'h00, "R7 tail byte"); a++;
         push_w(a, (pad % 2 == 1) ? 8'h60 : 8'h40, "R7 control byte");
         pend_done = 1; exp_page = pg;
      end
      fail_next = fail; page_next = pg;
      @(negedge clk);
      foreach (fb[i]) bq.push_back(fb[i]);
      rx_ctrl = ctrl; frm_len = LEN_W'(len); frm_valid = 1'b1;
      @(negedge clk);
      while (!frm_took) @(negedge clk);
      frm_valid = 1'b0;
      while (!(bq.size() == 0 && frm_ready && !pend_done && wq.size() == 0)) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(bq.size() == 0, {"R1 R10 stream drained: ", name}, bq.size(), 0);
      chk(wq.size() == 0 && !pend_done, {"R9 frame complete: ", name}, wq.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #3;
      chk(frm_ready && !alloc_req && !ram_we && !done && !byte_ready, "R8 reset idle",
          int'({frm_ready, alloc_req, ram_we, done}), 4'b1000);
      frame(70,   16'h0000, 0, 2'd0, "R1 disabled");
      frame(70,   16'h8100, 0, 2'd0, "R1 soft reset");
      frame(100,  16'h0100, 0, 2'd1, "even keep crc");
      frame(101,  16'h0100, 0, 2'd2, "R7 odd keep crc");
      frame(101,  16'h0300, 0, 2'd3, "R6 odd strip crc");
      frame(20,   16'h0100, 0, 2'd0, "R5 short even");
      frame(33,   16'h0300, 0, 2'd1, "R5 short odd");
      frame(64,   16'h0100, 0, 2'd2, "R5 exact minimum");
      frame(80,   16'h0100, 1, 2'd0, "R10 allocator full");
      frame(2040, 16'h0100, 0, 2'd1, "R3 too long");
      frame(2042, 16'h0300, 0, 2'd3, "R3 exactly fits");
      frame(1601, 16'h0100, 0, 2'd2, "R4 long odd");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      vec++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule